// File: doc/BRIEF.md
# Indirect Memory Access Port with Auto-Increment

This block gives a host processor byte-wide access to two internal RAMs through a small set of host registers. The host loads a 9-bit address pointer and a mode byte. It then reads or writes a single indirect data register, and each access lands in the RAM location the pointer names. One RAM holds one byte per location. The other holds a 16-bit word per location and is reached one byte at a time, low byte or high byte.

The mode byte picks the target RAM and the starting byte. It also carries two independent auto-increment enables, one for reads and one for writes. With the word RAM selected, successive data accesses alternate between the low and high byte, and the pointer advances only after a high-byte access. A whole table can therefore be streamed in or out as low, high, low, high. Both RAMs have 384 valid locations. Accesses beyond them are defined: writes are dropped and reads return zero.

Host accesses are single-cycle synchronous strobes. A data-register read returns the RAM contents in the same cycle as the read strobe.

Top module: `ind_mem_port`

## Requirements
- R1: After reset the pointer is 0 and the mode is all zeros (byte RAM selected, both auto-increments off), so reads of register 0 and register 1 return 0x00.
- R2: Register select 0 is the pointer bits 7:0 and select 2 is the indirect data register. Select 1 is the mode byte: bit 7 enables write increment, bit 6 enables read increment, bit 5 selects the word RAM, bit 4 selects the high byte (reads show the live byte), and bit 0 is pointer bit 8. On a mode read, bits 3:1 read as 0. Select 3 reads 0x00, and writing it changes nothing.
- R3: With the byte RAM selected, a data write stores at the pointer, and a data read returns the byte at the pointer during the read strobe, before any increment.
- R4: With the byte RAM selected, each data access advances the pointer by one only if its own direction's enable (bit 6 read, bit 7 write) is set. The 9-bit pointer wraps from 511 to 0.
- R5: With the word RAM selected and the access direction's increment enabled, accesses alternate low byte, high byte, then the low byte of the next location. The pointer advances only after a high-byte access.
- R6: With the word RAM selected and the direction's increment disabled, a low-byte access moves the selection to the high byte. Later accesses stay on the high byte, and the pointer is unchanged.
- R7: A host write to the pointer register or the mode register reloads the live byte select from mode bit 4.
- R8: At pointer values above 383, data writes are discarded and data reads return 0x00. Increment rules still apply.
- R9: If read and write strobes are both asserted, the access is treated as a write only, with a single pointer step.
- R10: With the pointer at 0, the low byte selected and write increment enabled, a stream of data writes fills the word RAM in order, low then high byte of each location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_sel | input | 2 | Register select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational |

## Verification
A wrong pointer or byte-toggle state shows up at the data register on the very next access, because that access returns or overwrites the wrong byte. The live select bit and the pointer can also be read back directly at any time. Streams in both directions are checked byte by byte against values written earlier. Reading the pointer after each sequence confirms exactly when it advanced, which exposes a skipped step or a premature step within one access. Boundary runs cover location 383, the first invalid location, and the 511-to-0 wrap.

// File: rtl/imp_pkg.sv
package imp_pkg;
    localparam int IMP_DEPTH = 384;
    localparam int IMP_AW    = 9;
    localparam int IMP_DW    = 8;

    localparam logic [1:0] SEL_PTR  = 2'd0;
    localparam logic [1:0] SEL_MODE = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;
    localparam logic [1:0] SEL_NONE = 2'd3;

    typedef struct packed {
        logic [IMP_AW-1:0] ptr;
        logic              wr_inc;
        logic              rd_inc;
        logic              word_sel;
        logic              hi_cfg;
        logic              hi_live;
    } ctl_t;
endpackage

// File: rtl/imp_byte_ram.sv
module imp_byte_ram #(
    parameter int DEPTH = 384,
    parameter int AW    = 9,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem_q [DEPTH];
    logic          in_range;

    assign in_range = (addr <= LAST);

    always_ff @(posedge clk) begin
        if (we && in_range) begin
            mem_q[addr] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (in_range) begin
            rdata = mem_q[addr];
        end
    end
endmodule

// File: rtl/imp_word_ram.sv
module imp_word_ram #(
    parameter int DEPTH = 384,
    parameter int AW    = 9,
    parameter int DW    = 8,
    parameter int LANES = 2
) (
    input  logic          clk,
    input  logic          we,
    input  logic          lane_hi,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

    logic [DW-1:0] lane_rd [LANES];
    logic [LW-1:0] lane_idx;

    assign lane_idx = LW'(lane_hi);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_we;
        assign lane_we = we && (lane_idx == LW'(g));
        imp_byte_ram #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_lane (
            .clk  (clk),
            .we   (lane_we),
            .addr (addr),
            .wdata(wdata),
            .rdata(lane_rd[g])
        );
    end

    assign rdata = lane_rd[lane_idx];
endmodule

// File: rtl/imp_ctrl.sv
module imp_ctrl
    import imp_pkg::*;
#(
    parameter int AW = IMP_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [1:0]    host_sel,
    input  logic [7:0]    host_wdata,
    output logic [AW-1:0] ptr,
    output logic          word_sel,
    output logic          hi_live,
    output logic [7:0]    mode_view,
    output logic          byte_we,
    output logic          word_we
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          wr_inc;
        logic          rd_inc;
        logic          word_sel;
        logic          hi_cfg;
        logic          hi_live;
    } st_t;

    st_t  st_d, st_q;
    logic data_acc;
    logic step_en;
    logic unused_mode_bits;

    assign unused_mode_bits = ^host_wdata[3:1];
    assign data_acc = (host_wr || host_rd) && (host_sel == SEL_DATA);
    assign step_en  = host_wr ? st_q.wr_inc : st_q.rd_inc;

    always_comb begin
        st_d    = st_q;
        byte_we = 1'b0;
        word_we = 1'b0;
        if (host_wr && host_sel == SEL_PTR) begin
            st_d.ptr[7:0] = host_wdata;
            st_d.hi_live  = st_q.hi_cfg;
        end
        if (host_wr && host_sel == SEL_MODE) begin
            st_d.wr_inc   = host_wdata[7];
            st_d.rd_inc   = host_wdata[6];
            st_d.word_sel = host_wdata[5];
            st_d.hi_cfg   = host_wdata[4];
            st_d.hi_live  = host_wdata[4];
            st_d.ptr[AW-1] = host_wdata[0];
        end
        if (data_acc) begin
            if (!st_q.word_sel) begin
                byte_we = host_wr;
                if (step_en) begin
                    st_d.ptr = st_q.ptr + AW'(1);
                end
            end else begin
                word_we = host_wr;
                if (!st_q.hi_live) begin
                    st_d.hi_live = 1'b1;
                end else if (step_en) begin
                    st_d.hi_live = 1'b0;
                    st_d.ptr     = st_q.ptr + AW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr       = st_q.ptr;
    assign word_sel  = st_q.word_sel;
    assign hi_live   = st_q.hi_live;
    assign mode_view = {st_q.wr_inc, st_q.rd_inc, st_q.word_sel, st_q.hi_live,
                        3'b000, st_q.ptr[AW-1]};

    AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc && !word_sel && step_en |=> ptr == $past(ptr) + AW'(1)); // R4
    AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc && !step_en |=> ptr == $past(ptr)); // R4
    AST_LOW_GOES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc && word_sel && !hi_live |=> hi_live && ptr == $past(ptr)); // R6
    AST_HIGH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc && word_sel && hi_live && step_en |=> !hi_live && ptr == $past(ptr) + AW'(1)); // R5
    AST_HIGH_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc && word_sel && hi_live && !step_en |=> hi_live); // R6
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_we && word_we)); // R9
endmodule

// File: rtl/ind_mem_port.sv
module ind_mem_port
    import imp_pkg::*;
#(
    parameter int DEPTH = IMP_DEPTH,
    parameter int AW    = IMP_AW
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [1:0] host_sel,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] ptr;
    logic          word_sel;
    logic          hi_live;
    logic [7:0]    mode_view;
    logic          byte_we;
    logic          word_we;
    logic [7:0]    byte_rd;
    logic [7:0]    word_rd;

    imp_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_sel  (host_sel),
        .host_wdata(host_wdata),
        .ptr       (ptr),
        .word_sel  (word_sel),
        .hi_live   (hi_live),
        .mode_view (mode_view),
        .byte_we   (byte_we),
        .word_we   (word_we)
    );

    imp_byte_ram #(.DEPTH(DEPTH), .AW(AW), .DW(8)) u_byte_ram (
        .clk  (clk),
        .we   (byte_we),
        .addr (ptr),
        .wdata(host_wdata),
        .rdata(byte_rd)
    );

    imp_word_ram #(.DEPTH(DEPTH), .AW(AW), .DW(8), .LANES(2)) u_word_ram (
        .clk    (clk),
        .we     (word_we),
        .lane_hi(hi_live),
        .addr   (ptr),
        .wdata  (host_wdata),
        .rdata  (word_rd)
    );

    always_comb begin
        unique case (host_sel)
            SEL_PTR:  host_rdata = ptr[7:0];
            SEL_MODE: host_rdata = mode_view;
            SEL_DATA: host_rdata = word_sel ? word_rd : byte_rd;
            default:  host_rdata = 8'h00;
        endcase
    end

    AST_INVALID_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_sel == SEL_DATA && ptr > LAST |-> host_rdata == 8'h00); // R8
    AST_SPARE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        host_sel == SEL_NONE |-> host_rdata == 8'h00); // R2
endmodule

// File: tb/sim_ind_mem_port.sv
module sim_ind_mem_port;
    localparam time TCLK = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [1:0] host_sel = 2'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;

    int checks = 0;
    int failures = 0;

    always #(TCLK / 2) clk = ~clk;

    ind_mem_port u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        host_sel = s; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        host_sel = s; host_rd = 1'b1;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] s, input logic [7:0] exp);
        logic [7:0] v;
        rd(s, v);
        check(req, v, exp);
    endtask

    task automatic t_reset();
        rd_chk("R1 ptr", 2'd0, 8'h00);
        rd_chk("R1 mode", 2'd1, 8'h00);
        rd_chk("R2 spare", 2'd3, 8'h00);
    endtask

    task automatic t_spare();
        wr(2'd1, 8'h80);
        wr(2'd3, 8'hFF);
        rd_chk("R2 spare write no effect mode", 2'd1, 8'h80);
        rd_chk("R2 spare read", 2'd3, 8'h00);
    endtask

    task automatic t_byte_ram();
        wr(2'd1, 8'h80); wr(2'd0, 8'h10);
        wr(2'd2, 8'hAA); wr(2'd2, 8'hBB); wr(2'd2, 8'hCC);
        rd_chk("R4 write step", 2'd0, 8'h13);
        wr(2'd1, 8'h40); wr(2'd0, 8'h10);
        rd_chk("R3 read 0", 2'd2, 8'hAA);
        rd_chk("R3 read 1", 2'd2, 8'hBB);
        rd_chk("R3 read 2", 2'd2, 8'hCC);
        rd_chk("R4 read step", 2'd0, 8'h13);
        wr(2'd1, 8'h80); wr(2'd0, 8'h11);
        rd_chk("R4 read no step", 2'd2, 8'hBB);
        rd_chk("R4 read no step again", 2'd2, 8'hBB);
        rd_chk("R4 read no step ptr", 2'd0, 8'h11);
        wr(2'd1, 8'h40); wr(2'd0, 8'h20);
        wr(2'd2, 8'h01); wr(2'd2, 8'h02);
        rd_chk("R4 write no step ptr", 2'd0, 8'h20);
        rd_chk("R3 last write kept", 2'd2, 8'h02);
    endtask

    task automatic t_range();
        wr(2'd1, 8'h81); wr(2'd0, 8'h7F);
        wr(2'd2, 8'h77); wr(2'd2, 8'h66);
        rd_chk("R8 ptr steps past end", 2'd0, 8'h81);
        wr(2'd1, 8'h41); wr(2'd0, 8'h7F);
        rd_chk("R8 loc 383 valid", 2'd2, 8'h77);
        rd_chk("R8 loc 384 reads zero", 2'd2, 8'h00);
        wr(2'd1, 8'h81); wr(2'd0, 8'hFF);
        wr(2'd2, 8'h5A);
        rd_chk("R4 wrap ptr low", 2'd0, 8'h00);
        rd_chk("R4 wrap ptr bit8", 2'd1, 8'h80);
    endtask

    task automatic t_word_fill();
        wr(2'd1, 8'hA0); wr(2'd0, 8'h00);
        for (int i = 0; i < 8; i++) wr(2'd2, 8'(8'h10 + i));
        rd_chk("R10 ptr after fill", 2'd0, 8'h04);
        rd_chk("R5 low byte live after pair", 2'd1, 8'hA0);
        wr(2'd1, 8'h60); wr(2'd0, 8'h00);
        for (int i = 0; i < 8; i++) rd_chk("R10 read back", 2'd2, 8'(8'h10 + i));
        rd_chk("R5 read ptr", 2'd0, 8'h04);
        wr(2'd1, 8'hB0); wr(2'd0, 8'h05);
        wr(2'd2, 8'h42);
        rd_chk("R5 high step ptr", 2'd0, 8'h06);
        rd_chk("R5 back to low", 2'd1, 8'hA0);
    endtask

    task automatic t_word_noinc();
        wr(2'd1, 8'h20); wr(2'd0, 8'h02);
        rd_chk("R6 low first", 2'd2, 8'h14);
        rd_chk("R6 then high", 2'd2, 8'h15);
        rd_chk("R6 stays high", 2'd2, 8'h15);
        rd_chk("R6 ptr held", 2'd0, 8'h02);
        rd_chk("R6 live high", 2'd1, 8'h30);
        wr(2'd2, 8'h99);
        wr(2'd0, 8'h02);
        rd_chk("R7 ptr write reloads low", 2'd2, 8'h14);
        wr(2'd1, 8'h30);
        rd_chk("R7 mode write selects high", 2'd2, 8'h99);
        rd_chk("R6 ptr still held", 2'd0, 8'h02);
    endtask

    task automatic t_both();
        wr(2'd1, 8'hC0); wr(2'd0, 8'h30);
        host_sel = 2'd2; host_wdata = 8'h3C; host_wr = 1'b1; host_rd = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        rd_chk("R9 single step", 2'd0, 8'h31);
        wr(2'd1, 8'h00); wr(2'd0, 8'h30);
        rd_chk("R9 write taken", 2'd2, 8'h3C);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_spare();
        t_byte_ram();
        t_range();
        t_word_fill();
        t_word_noinc();
        t_both();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule